// File: doc/BRIEF.md
# Double-Buffered Converter Code Register

This block holds the 16-bit code that a digital-to-analog converter core turns into a voltage. It has two holding stages. A first stage captures a word from a parallel bus. A second stage drives the converter core. Because the second stage is loaded separately, a system can fill the first stage of several converters one at a time and then update all of their outputs together with one common strobe.

Each stage behaves like a level-sensitive latch. It is enabled by its own active-low select together with a shared active-low write strobe. Here the latches are modelled on a fast sampling clock. The bus and the controls pass through a synchroniser, and each stage updates on the clock edge after its enable condition is seen. An active-low clear acts at once and overrides everything else: it empties the first stage and puts the second stage at the bipolar-zero code.

The code reaches the converter core in two forms. One is two's complement, where 0x7FFF is plus full scale, 0x8000 is minus full scale and 0x0000 is mid-scale. The other is offset binary.

Top module: `dac_dbuf_reg`

## Requirements
- R1: While `rst` is high at a rising edge, both stages take their cleared values: `code_tc` = 0x0000 and `code_ob` = 0x8000, and the first stage holds zero.
- R2: With `in_en_n`=0, `out_en_n`=1 and `wr_n`=0, only the first stage loads `din`. `code_tc` and `code_ob` do not change.
- R3: With `in_en_n`=1, `out_en_n`=0 and `wr_n`=0, `code_tc` takes the value held in the first stage, and `din` has no effect.
- R4: With `in_en_n`, `out_en_n` and `wr_n` all 0 and `clr_n`=1, the path is transparent and `code_tc` follows `din`.
- R5: While `wr_n`=1, neither stage changes, whatever the enables and `din` are.
- R6: While both `in_en_n` and `out_en_n` are 1, neither stage changes, even with `wr_n`=0.
- R7: When `clr_n` goes to 0, the outputs change without waiting for a clock edge: `code_tc` becomes 0x0000 (bipolar zero), `code_ob` becomes 0x8000, and the first stage becomes all zeros.
- R8: While `clr_n`=0, enabled writes have no effect, so `code_tc` stays 0x0000.
- R9: After `clr_n` returns to 1, both stages keep their cleared values until an enabled write arrives. A write that is already pending at release takes effect on the third rising edge after the release, and not on the second.
- R10: `code_ob` always equals `code_tc` with bit 15 (the MSB) inverted. Two's-complement 0x7FFF is plus full scale and 0x8000 is minus full scale.
- R11: A change of the controls or of `din` made between edges shows at the outputs on the third rising edge after the change. The outputs still show the old value after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Asynchronous clear, active low |
| in_en_n | input | 1 | First-stage select, active low |
| out_en_n | input | 1 | Second-stage select, active low |
| wr_n | input | 1 | Shared write strobe, active low |
| din | input | 16 | Parallel data word, bit 15 is the MSB |
| code_tc | output | 16 | Converter code, two's complement |
| code_ob | output | 16 | Converter code, offset binary |

## Verification
The first stage has no port of its own. A corrupted or stale first stage therefore stays hidden until the next second-stage-only transfer, which copies it to `code_tc` three rising edges after the transfer is issued. For this reason every check on the first stage is made through such a transfer. A wrong decode of the controls, or a missing synchroniser stage, shows as a code that arrives one edge early or late, or never arrives. Sampling exactly after the second and the third edge detects both. A clear that fails to act on the first stage is caught by a transfer made after the clear is released, and that transfer must produce 0x0000.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

  // Number of control lines carried alongside the data word.
  localparam int CTRL_BITS = 3;

  // Which stages accept new data in the current cycle.
  typedef enum logic [1:0] {
    DB_HOLD   = 2'd0,
    DB_FIRST  = 2'd1,
    DB_SECOND = 2'd2,
    DB_BOTH   = 2'd3
  } db_mode_e;

  // Active-low selects and strobe are turned into a load mode.
  function automatic db_mode_e db_decode(input logic sel_first_n,
                                         input logic sel_second_n,
                                         input logic strobe_n);
    db_mode_e m;
    if (strobe_n) m = DB_HOLD;
    else          m = db_mode_e'({~sel_second_n, ~sel_first_n});
    return m;
  endfunction

endpackage

// File: rtl/dac_dbuf_sync.sv
module dac_dbuf_sync #(
  parameter int          W        = 1,
  parameter int          STAGES   = 2,
  parameter logic [W-1:0] ARST_VAL = '0,
  parameter logic [W-1:0] RST_VAL  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] chain [STAGES];

      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          for (int i = 0; i < STAGES; i++) chain[i] <= ARST_VAL;
        end else if (rst) begin
          for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
          chain[0] <= d;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end

      assign q = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dac_dbuf_stage.sv
module dac_dbuf_stage #(
  parameter int           W       = 16,
  parameter logic [W-1:0] CLR_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         hold_clr,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Clear acts asynchronously; the synchronised clear keeps the stage
  // at its cleared value until release has passed the synchroniser.
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)               q <= CLR_VAL;
    else if (rst || hold_clr) q <= CLR_VAL;
    else if (load)            q <= d;
  end

endmodule

// File: rtl/dac_dbuf_reg.sv
module dac_dbuf_reg
  import dac_dbuf_pkg::*;
#(
  parameter int                DATA_W      = 16,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] BPZ_CODE    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              in_en_n,
  input  logic              out_en_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] code_tc,
  output logic [DATA_W-1:0] code_ob
);

  localparam int                PIPE_W   = DATA_W + CTRL_BITS;
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] IN_CLR   = '0;
  localparam logic [DATA_W-1:0] OB_CLR   = BPZ_CODE ^ MSB_MASK;
  localparam logic [PIPE_W-1:0] PIPE_IDLE = {{CTRL_BITS{1'b1}}, {DATA_W{1'b0}}};

  logic [PIPE_W-1:0] pipe_q;
  logic              s_wr_n, s_out_n, s_in_n;
  logic [DATA_W-1:0] s_din;
  logic              clr_run;
  db_mode_e          mode;
  logic              first_ld, second_ld;
  logic [DATA_W-1:0] in_q, in_next;

  // Controls and data share one synchroniser so they stay aligned.
  dac_dbuf_sync #(
    .W       (PIPE_W),
    .STAGES  (SYNC_STAGES),
    .ARST_VAL(PIPE_IDLE),
    .RST_VAL (PIPE_IDLE)
  ) u_pipe (
    .clk   (clk),
    .rst   (rst),
    .arst_n(1'b1),
    .d     ({wr_n, out_en_n, in_en_n, din}),
    .q     (pipe_q)
  );

  assign {s_wr_n, s_out_n, s_in_n, s_din} = pipe_q;

  // Clear release is synchronised; assertion is immediate.
  dac_dbuf_sync #(
    .W       (1),
    .STAGES  (SYNC_STAGES),
    .ARST_VAL(1'b0),
    .RST_VAL (1'b1)
  ) u_clr (
    .clk   (clk),
    .rst   (rst),
    .arst_n(clr_n),
    .d     (1'b1),
    .q     (clr_run)
  );

  assign mode      = db_decode(s_in_n, s_out_n, s_wr_n);
  assign first_ld  = (mode == DB_FIRST)  || (mode == DB_BOTH);
  assign second_ld = (mode == DB_SECOND) || (mode == DB_BOTH);
  assign in_next   = first_ld ? s_din : in_q;

  dac_dbuf_stage #(.W(DATA_W), .CLR_VAL(IN_CLR)) u_first (
    .clk(clk), .rst(rst), .clr_n(clr_n), .hold_clr(~clr_run),
    .load(first_ld), .d(s_din), .q(in_q)
  );

  dac_dbuf_stage #(.W(DATA_W), .CLR_VAL(BPZ_CODE)) u_second (
    .clk(clk), .rst(rst), .clr_n(clr_n), .hold_clr(~clr_run),
    .load(second_ld), .d(in_next), .q(code_tc)
  );

  dac_dbuf_stage #(.W(DATA_W), .CLR_VAL(OB_CLR)) u_second_ob (
    .clk(clk), .rst(rst), .clr_n(clr_n), .hold_clr(~clr_run),
    .load(second_ld), .d(in_next ^ MSB_MASK), .q(code_ob)
  );

endmodule

// File: rtl/dac_dbuf_chk.sv
module dac_dbuf_chk #(
  parameter int           W   = 16,
  parameter logic [W-1:0] BPZ = '0
) (
  input logic         clk,
  input logic         rst,
  input logic         clr_n,
  input logic         in_en_n,
  input logic         out_en_n,
  input logic         wr_n,
  input logic [W-1:0] din,
  input logic [W-1:0] code_tc,
  input logic [W-1:0] code_ob,
  input logic [W-1:0] in_q
);

  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

  AST_OB_MIRROR: assert property (@(posedge clk) disable iff (rst)
    code_ob == (code_tc ^ MSB)); // R10

  AST_CLEAR_FORCE: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !$past(clr_n)) |-> (code_tc == BPZ && in_q == '0 && code_ob == (BPZ ^ MSB))); // R7

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_n, 3) && !$past(rst) && clr_n && $past(clr_n)) |-> $stable(code_tc)); // R5

  AST_THRU_PASS: assert property (@(posedge clk) disable iff (rst)
    ($past(!wr_n && !in_en_n && !out_en_n, 3) &&
     $past(clr_n) && $past(clr_n, 2) && $past(clr_n, 3) &&
     !$past(rst) && !$past(rst, 2) && !$past(rst, 3))
    |-> code_tc == $past(din, 3)); // R4

  AST_SECOND_FROM_FIRST: assert property (@(posedge clk) disable iff (rst)
    ($past(!wr_n && in_en_n && !out_en_n, 3) &&
     $past(clr_n) && $past(clr_n, 2) && $past(clr_n, 3) &&
     !$past(rst) && !$past(rst, 2) && !$past(rst, 3))
    |-> code_tc == $past(in_q)); // R3

endmodule

bind dac_dbuf_reg dac_dbuf_chk #(.W(DATA_W), .BPZ(BPZ_CODE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .clr_n   (clr_n),
  .in_en_n (in_en_n),
  .out_en_n(out_en_n),
  .wr_n    (wr_n),
  .din     (din),
  .code_tc (code_tc),
  .code_ob (code_ob),
  .in_q    (in_q)
);

// File: tb/dac_dbuf_reg_tb.sv
module dac_dbuf_reg_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        clr_n;
  logic        in_en_n, out_en_n, wr_n;
  logic [15:0] din;
  logic [15:0] code_tc, code_ob;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk; // 250 MHz

  dac_dbuf_reg u_dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .in_en_n(in_en_n),
    .out_en_n(out_en_n), .wr_n(wr_n), .din(din),
    .code_tc(code_tc), .code_ob(code_ob)
  );

  // {in_en_n, out_en_n, wr_n, din, expected code_tc}
  localparam int NVEC = 12;
  localparam logic [34:0] VEC [NVEC] = '{
    {3'b010, 16'hA123, 16'h0000},  // R2 first stage only
    {3'b100, 16'hFFFF, 16'hA123},  // R3 transfer, bus ignored
    {3'b110, 16'h5555, 16'hA123},  // R6 both selects high
    {3'b001, 16'h1111, 16'hA123},  // R5 strobe high
    {3'b100, 16'h2222, 16'hA123},  // R5 R6 first stage untouched
    {3'b000, 16'h7FFF, 16'h7FFF},  // R4 plus full scale
    {3'b000, 16'h8000, 16'h8000},  // R4 minus full scale
    {3'b000, 16'h0000, 16'h0000},  // R4 bipolar zero
    {3'b010, 16'h1234, 16'h0000},  // R2 again
    {3'b111, 16'h9999, 16'h0000},  // R5 all high
    {3'b100, 16'h0000, 16'h1234},  // R3 transfer
    {3'b111, 16'hABCD, 16'h1234}   // R5 R6 idle
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 8:  return "R2";
      1, 10: return "R3";
      2:     return "R6";
      3, 9:  return "R5";
      4, 11: return "R5/R6";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_both(input string tag, input logic [15:0] exp);
    chk(tag, code_tc, exp);
    chk({tag, " R10"}, code_ob, exp ^ 16'h8000);
  endtask

  task automatic drive(input logic [2:0] c, input logic [15:0] d);
    {in_en_n, out_en_n, wr_n} = c;
    din = d;
  endtask

  initial begin
    rst = 1'b1; clr_n = 1'b1; drive(3'b111, 16'h0000);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_both("R1 reset", 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i][34:32], VEC[i][31:16]);
      repeat (4) @(negedge clk);
      chk_both(vec_tag(i), VEC[i][15:0]);
    end

    // R11 latency: old value after two edges, new after three
    @(negedge clk); drive(3'b000, 16'h0F0F);
    repeat (2) @(negedge clk);
    chk("R11 after 2 edges", code_tc, 16'h1234);
    @(negedge clk);
    chk("R11 after 3 edges", code_tc, 16'h0F0F);

    // R7 asynchronous clear
    drive(3'b010, 16'h4321);
    repeat (4) @(negedge clk);
    drive(3'b111, 16'h4321);
    clr_n = 1'b0;
    #1;
    chk_both("R7 async clear", 16'h0000);

    // R8 writes ignored during clear
    @(negedge clk); drive(3'b000, 16'h6666);
    repeat (5) @(negedge clk);
    chk_both("R8 clear overrides", 16'h0000);

    // R9 held after release; R7 first stage was emptied
    drive(3'b111, 16'h6666);
    repeat (3) @(negedge clk);
    clr_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 held after release", code_tc, 16'h0000);
    drive(3'b100, 16'h7777);
    repeat (4) @(negedge clk);
    chk("R7 first stage cleared", code_tc, 16'h0000);

    // R9 pending write at release lands on third edge
    clr_n = 1'b0;
    drive(3'b000, 16'h3C3C);
    repeat (3) @(negedge clk);
    clr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 release after 2 edges", code_tc, 16'h0000);
    @(negedge clk);
    chk_both("R9 release after 3 edges", 16'h3C3C);

    // R1 reset in the middle of operation
    drive(3'b111, 16'h0000);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk_both("R1 mid-run reset", 16'h0000);
    rst = 1'b0;
    drive(3'b100, 16'h5A5A);
    repeat (4) @(negedge clk);
    chk("R1 first stage reset", code_tc, 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule